// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level translation structure held in memory. A request supplies the linear address, whether the access is a write, and whether it comes from user mode. The walker reads the directory entry and, unless that entry maps a 4 MB region directly, the table entry below it. It checks presence and permissions and then returns either a physical address or a fault code.

On a successful walk it marks each entry it used as accessed. On a permitted write it also marks the leaf entry as dirty. Each of these updates is a read-modify-write, and it is only issued when a flag actually changes. Memory is reached through a single 32-bit read/write port that completes a transfer in any cycle where `mem_ready` is high. The walker handles one translation at a time.

Entry layout: bits 31:12 hold the frame number. Bit 0 is present, bit 1 is writable, bit 2 is user-allowed, bit 5 is accessed and bit 6 is dirty. Bit 7 of a directory entry selects a 4 MB page, in which case bits 31:22 hold the large frame.

Top module: `pt_walker`

## Requirements
- R1: For a 4 KB mapping, the response address is the table entry's bits 31:12 followed by linear bits 11:0.
- R2: The directory entry is read at {dir_frame, linear[31:22], 2'b00}, and the table entry is then read at {directory entry[31:12], linear[21:12], 2'b00}.
- R3: When the directory entry has bit 7 set, no second read is made, and the response address is directory entry bits 31:22 followed by linear bits 21:0.
- R4: A clear present bit (bit 0) at either level ends the walk with fault code 1, a physical address of zero, and no memory writes.
- R5: A user-mode access is refused with fault code 2 unless bit 2 is set in every entry used. This cause takes precedence over a write violation, and no memory writes are made.
- R6: A write, at either privilege level, is refused with fault code 3 unless bit 1 is set in every entry used. No memory writes are made.
- R7: A successful walk sets bit 5 in each entry used. The write back is issued only when the flag was clear, its data is the read value with the flag set, and the directory entry is written before the table entry.
- R8: A permitted write sets bit 6 in the leaf entry (the table entry, or the directory entry for a 4 MB page). A read never sets bit 6.
- R9: `req_ready` is high only while idle. `rsp_valid` is a one-cycle pulse carrying `rsp_fault` (0 means success).
- R10: A memory transfer completes only in a cycle with `mem_ready` high, and the address, write enable and write data hold steady while the walker waits.
- R11: After reset, `req_ready` is 1, while `rsp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_frame | input | 20 | Frame number of the directory |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access from user mode |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 2 | 0 ok, 1 not present, 2 privilege, 3 write protect |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when mem_ready |
| mem_ready | input | 1 | Transfer completes this cycle |

## Verification
The bench sets up directory and table entries whose flags are cleared one at a time. A walker that takes the OR of the permission flags instead of the AND, or that checks only one level, would let a user or write access through; the bench would then see fault 0 where it expects 2 or 3. A walker that writes flags back on a fault, or that rewrites an entry whose accessed bit is already set, shows up as a wrong write count. A walker that sets the dirty bit on a read, or that treats a large page as a two-level walk, produces wrong write data or a second read address. Running the same walk while stalling the memory port exposes a walker that samples read data before `mem_ready`.

// File: rtl/pt_walker_pkg.sv
`timescale 1ns/1ps
package pt_walker_pkg;
  localparam int ADDR_W  = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int ENT_SH  = 2;
  localparam int FRAME_W = ADDR_W - OFF_W;

  localparam int B_PRES  = 0;
  localparam int B_WR    = 1;
  localparam int B_USER  = 2;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;
  localparam int B_BIG   = 7;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PRIV   = 2'd2,
    FLT_WPROT  = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_TBL_RD,
    ST_DIR_UPD,
    ST_TBL_UPD,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/pt_perm_chk.sv
`timescale 1ns/1ps
module pt_perm_chk
  import pt_walker_pkg::*;
(
  input  logic   present,
  input  logic   eff_wr,
  input  logic   eff_user,
  input  logic   is_write,
  input  logic   is_user,
  output fault_e verdict
);
  always_comb begin
    if (!present)                verdict = FLT_ABSENT;
    else if (is_user && !eff_user) verdict = FLT_PRIV;
    else if (is_write && !eff_wr)  verdict = FLT_WPROT;
    else                         verdict = FLT_NONE;
  end
endmodule

// File: rtl/pt_addr_gen.sv
`timescale 1ns/1ps
module pt_addr_gen #(
  parameter int AW  = 32,
  parameter int OW  = 12,
  parameter int IW  = 10,
  parameter int ESH = 2
) (
  input  logic [AW-OW-1:0] dir_frame,
  input  logic [AW-1:0]    vaddr,
  input  logic [AW-1:0]    dir_ent,
  input  logic [AW-1:0]    tbl_ent,
  output logic [AW-1:0]    dir_ent_addr,
  output logic [AW-1:0]    tbl_ent_addr,
  output logic [AW-1:0]    pa_small,
  output logic [AW-1:0]    pa_large
);
  localparam int BIG_OFF = OW + IW;

  assign dir_ent_addr = {dir_frame, vaddr[AW-1:BIG_OFF], {ESH{1'b0}}};
  assign tbl_ent_addr = {dir_ent[AW-1:OW], vaddr[BIG_OFF-1:OW], {ESH{1'b0}}};
  assign pa_small     = {tbl_ent[AW-1:OW], vaddr[OW-1:0]};
  assign pa_large     = {dir_ent[AW-1:BIG_OFF], vaddr[BIG_OFF-1:0]};
endmodule

// File: rtl/pt_flag_upd.sv
`timescale 1ns/1ps
module pt_flag_upd #(
  parameter int W     = 32,
  parameter int A_POS = 5,
  parameter int D_POS = 6
) (
  input  logic [W-1:0] ent,
  input  logic         set_dirty,
  output logic [W-1:0] ent_new,
  output logic         need_wr
);
  always_comb begin
    ent_new        = ent;
    ent_new[A_POS] = 1'b1;
    if (set_dirty) ent_new[D_POS] = 1'b1;
  end
  assign need_wr = (ent_new != ent);
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FRAME_W-1:0]  dir_frame,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_vaddr,
  input  logic                req_write,
  input  logic                req_user,
  output logic                rsp_valid,
  output logic [1:0]          rsp_fault,
  output logic [ADDR_W-1:0]   rsp_paddr,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [ADDR_W-1:0]   mem_wdata,
  input  logic [ADDR_W-1:0]   mem_rdata,
  input  logic                mem_ready
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  walk_st_e            st_q, st_d;
  logic [ADDR_W-1:0]   va_q, pde_q, pte_q;
  logic                wr_q, usr_q, big_q, big_d;
  fault_e              flt_q, flt_d;
  logic                accept, xfer, ld_pde, ld_pte, ld_flt;

  logic [ADDR_W-1:0]   dir_ea, tbl_ea, pa_small, pa_large;
  logic [ADDR_W-1:0]   pde_new, pte_new;
  logic                pde_need, pte_need;
  logic                chk_wr, chk_user;
  fault_e              verdict;

  pt_addr_gen #(.AW(ADDR_W), .OW(OFF_W), .IW(IDX_W), .ESH(ENT_SH)) u_addr (
    .dir_frame(dir_frame), .vaddr(va_q), .dir_ent(pde_q), .tbl_ent(pte_q),
    .dir_ent_addr(dir_ea), .tbl_ent_addr(tbl_ea),
    .pa_small(pa_small), .pa_large(pa_large)
  );

  // effective permission: AND across the levels walked so far
  assign chk_wr   = (st_q == ST_TBL_RD) ? (pde_q[B_WR]   & mem_rdata[B_WR])   : mem_rdata[B_WR];
  assign chk_user = (st_q == ST_TBL_RD) ? (pde_q[B_USER] & mem_rdata[B_USER]) : mem_rdata[B_USER];

  pt_perm_chk u_perm (
    .present(mem_rdata[B_PRES]), .eff_wr(chk_wr), .eff_user(chk_user),
    .is_write(wr_q), .is_user(usr_q), .verdict(verdict)
  );

  pt_flag_upd #(.W(ADDR_W), .A_POS(B_ACC), .D_POS(B_DIRTY)) u_dir_flags (
    .ent(pde_q), .set_dirty(big_q & wr_q), .ent_new(pde_new), .need_wr(pde_need)
  );
  pt_flag_upd #(.W(ADDR_W), .A_POS(B_ACC), .D_POS(B_DIRTY)) u_tbl_flags (
    .ent(pte_q), .set_dirty(wr_q), .ent_new(pte_new), .need_wr(pte_need)
  );

  assign accept = (st_q == ST_IDLE) && req_valid;
  assign xfer   = mem_req && mem_ready;

  // next state
  always_comb begin
    st_d   = st_q;
    flt_d  = flt_q;
    big_d  = big_q;
    ld_pde = 1'b0;
    ld_pte = 1'b0;
    ld_flt = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d = ST_DIR_RD; flt_d = FLT_NONE; ld_flt = 1'b1;
      end
      ST_DIR_RD: if (mem_ready) begin
        ld_pde = 1'b1;
        big_d  = mem_rdata[B_BIG];
        if (verdict == FLT_ABSENT || (mem_rdata[B_BIG] && verdict != FLT_NONE)) begin
          st_d = ST_RESP; flt_d = verdict; ld_flt = 1'b1;
        end else if (mem_rdata[B_BIG]) st_d = ST_DIR_UPD;
        else                           st_d = ST_TBL_RD;
      end
      ST_TBL_RD: if (mem_ready) begin
        ld_pte = 1'b1;
        if (verdict != FLT_NONE) begin
          st_d = ST_RESP; flt_d = verdict; ld_flt = 1'b1;
        end else st_d = ST_DIR_UPD;
      end
      ST_DIR_UPD: if (!pde_need || mem_ready) st_d = big_q ? ST_RESP : ST_TBL_UPD;
      ST_TBL_UPD: if (!pte_need || mem_ready) st_d = ST_RESP;
      ST_RESP:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q  <= ST_IDLE;
      va_q  <= '0;
      wr_q  <= 1'b0;
      usr_q <= 1'b0;
      pde_q <= '0;
      pte_q <= '0;
      big_q <= 1'b0;
      flt_q <= FLT_NONE;
    end else begin
      st_q <= st_d;
      if (accept) begin
        va_q  <= req_vaddr;
        wr_q  <= req_write;
        usr_q <= req_user;
      end
      if (ld_pde) begin
        pde_q <= mem_rdata;
        big_q <= big_d;
      end
      if (ld_pte) pte_q <= mem_rdata;
      if (ld_flt) flt_q <= flt_d;
    end
  end

  // outputs
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st_q)
      ST_DIR_RD:  begin mem_req = 1'b1; mem_addr = dir_ea; end
      ST_TBL_RD:  begin mem_req = 1'b1; mem_addr = tbl_ea; end
      ST_DIR_UPD: begin mem_req = pde_need; mem_we = 1'b1; mem_addr = dir_ea; mem_wdata = pde_new; end
      ST_TBL_UPD: begin mem_req = pte_need; mem_we = 1'b1; mem_addr = tbl_ea; mem_wdata = pte_new; end
      default: ;
    endcase
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_fault = flt_q;
  assign rsp_paddr = (flt_q != FLT_NONE) ? '0 : (big_q ? pa_large : pa_small);

  logic unused_xfer;
  assign unused_xfer = xfer;
endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [1:0]  rsp_fault,
  input logic [31:0] rsp_paddr,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready
);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !rsp_valid));

  // R4
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == 32'd0));

  // R2
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R7
  accessed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[5]);
endmodule

bind pt_walker pt_walker_chk u_pt_walker_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk;
  logic        rst_n;
  logic [19:0] dir_frame;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_vaddr;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int vectors = 0;
  int errors  = 0;
  logic stall = 1'b0;
  logic [1:0] cyc = 2'd0;

  logic [31:0] mem [0:4095];
  logic [31:0] rd_a [0:3];
  logic [31:0] wr_a [0:3];
  logic [31:0] wr_d [0:3];
  int rd_cnt = 0;
  int wr_cnt = 0;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .dir_frame(dir_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign mem_ready = !stall || (cyc == 2'd0);
  assign mem_rdata = mem[mem_addr[13:2]];

  always @(posedge clk) begin
    cyc = cyc + 2'd1;
    if (rst_n && mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[13:2]] = mem_wdata;
        if (wr_cnt < 4) begin wr_a[wr_cnt] = mem_addr; wr_d[wr_cnt] = mem_wdata; end
        wr_cnt = wr_cnt + 1;
      end else begin
        if (rd_cnt < 4) rd_a[rd_cnt] = mem_addr;
        rd_cnt = rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    mem[a[13:2]] = d;
  endtask

  task automatic walk(input string tag, input logic [31:0] va, input logic wr, input logic usr,
                      input logic [1:0] exp_f, input logic [31:0] exp_pa, input int exp_wr);
    bit seen;
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R9 busy"}, {31'd0, req_ready}, 32'd0);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (rsp_valid) seen = 1;
      else @(negedge clk);
    end
    chk({tag, " R9 response seen"}, {31'd0, seen}, 32'd1);
    chk({tag, " fault"}, {30'd0, rsp_fault}, {30'd0, exp_f});
    chk({tag, " paddr"}, rsp_paddr, exp_pa);
    chk({tag, " writes"}, wr_cnt, exp_wr);
    @(negedge clk);
    chk({tag, " R9 pulse"}, {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R11 ready", {31'd0, req_ready}, 32'd1);
    chk("R11 rsp", {31'd0, rsp_valid}, 32'd0);
    chk("R11 memreq", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_small_page;
    poke(32'h1004, 32'h0000_2007);
    poke(32'h200C, 32'hABCD_E007);
    walk("R1 4k read", 32'h0040_3ABC, 1'b0, 1'b1, 2'd0, 32'hABCD_EABC, 2);
    chk("R2 dir addr", rd_a[0], 32'h0000_1004);
    chk("R2 tbl addr", rd_a[1], 32'h0000_200C);
    chk("R7 dir wr addr", wr_a[0], 32'h0000_1004);
    chk("R7 dir wr data", wr_d[0], 32'h0000_2027);
    chk("R7 tbl wr addr", wr_a[1], 32'h0000_200C);
    chk("R8 no dirty on read", wr_d[1], 32'hABCD_E027);
    walk("R7 no rewrite", 32'h0040_3ABC, 1'b0, 1'b0, 2'd0, 32'hABCD_EABC, 0);
    walk("R8 write", 32'h0040_3123, 1'b1, 1'b1, 2'd0, 32'hABCD_E123, 1);
    chk("R8 dirty addr", wr_a[0], 32'h0000_200C);
    chk("R8 dirty data", wr_d[0], 32'hABCD_E067);
  endtask

  task automatic t_large_page;
    poke(32'h10C8, 32'h7FC0_0087);
    walk("R3 4m write", 32'h0C81_2345, 1'b1, 1'b1, 2'd0, 32'h7FC1_2345, 1);
    chk("R3 one read", rd_cnt, 1);
    chk("R8 big dirty", wr_d[0], 32'h7FC0_00E7);
    poke(32'h10CC, 32'h8000_0085);
    walk("R6 4m ro write", 32'h0CC0_0010, 1'b1, 1'b0, 2'd3, 32'h0, 0);
  endtask

  task automatic t_absent;
    poke(32'h1080, 32'h0000_0000);
    walk("R4 dir absent", 32'h0800_0000, 1'b0, 1'b0, 2'd1, 32'h0, 0);
    poke(32'h1008, 32'h0000_3007);
    poke(32'h3014, 32'h1234_5006);
    walk("R4 tbl absent", 32'h0080_5000, 1'b1, 1'b0, 2'd1, 32'h0, 0);
    chk("R4 dir untouched", mem[12'h402], 32'h0000_3007);
  endtask

  task automatic t_perm;
    poke(32'h1010, 32'h0000_3003);
    poke(32'h3018, 32'h5555_5007);
    walk("R5 dir super", 32'h0100_6000, 1'b0, 1'b1, 2'd2, 32'h0, 0);
    walk("R5 super ok", 32'h0100_6000, 1'b0, 1'b0, 2'd0, 32'h5555_5000, 2);
    poke(32'h1014, 32'h0000_3005);
    poke(32'h301C, 32'h6666_6003);
    walk("R5 precedence", 32'h0140_7000, 1'b1, 1'b1, 2'd2, 32'h0, 0);
    walk("R6 super ro", 32'h0140_7000, 1'b1, 1'b0, 2'd3, 32'h0, 0);
    walk("R6 read ok", 32'h0140_7000, 1'b0, 1'b0, 2'd0, 32'h6666_6000, 2);
  endtask

  task automatic t_stall;
    stall = 1'b1;
    poke(32'h2020, 32'h0BEE_F007);
    walk("R10 stalled", 32'h0040_8123, 1'b0, 1'b1, 2'd0, 32'h0BEE_F123, 1);
    chk("R10 tbl addr", rd_a[1], 32'h0000_2020);
    chk("R10 wr data", wr_d[0], 32'h0BEE_F027);
    stall = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    dir_frame = 20'h00001;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_small_page;
    t_large_page;
    t_absent;
    t_perm;
    t_stall;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule